// File: doc/BRIEF.md
# Asynchronous PSRAM Write Sequencer

This block sits on the synchronous side of a chip and converts one write request at a time into the pin sequence of a 16-bit asynchronous pseudo-static RAM. A request carries a 21-bit word address, 16 bits of data and two byte-lane enables. When accepted, the sequencer presents address and data and pulls chip enable, write enable and the selected lane strobes low on the same clock edge. It holds them low for a counted pulse, raises them together, keeps the address steady through a recovery interval and keeps chip enable high for a minimum interval before it accepts the next request.

Every interval is a clock count computed at elaboration as the rounded-up quotient of a nanosecond minimum and the clock period. The pulse count is also raised when needed so that the pulse and recovery together meet the minimum cycle time. Output enable is held high whenever the memory is selected, so the device never sees a read. An elaboration check refuses parameter sets under which chip enable would stay low past the 1000 ns ceiling. With the defaults (20 ns clock), the pulse is 3 cycles, recovery is 1 cycle and the chip-enable high gap is 1 cycle.

Top module: `psram_wr_ctrl`

## Requirements
- R1: While reset is low, mem_ce_n, mem_we_n, mem_lb_n, mem_ub_n and mem_oe_n are 1, mem_dq_oe is 0 and req_ready is 1.
- R2: When req_valid and req_ready are both 1 at a clock edge and req_be is not 00, that edge drives mem_ce_n and mem_we_n to 0, mem_lb_n to the inverse of req_be[0] (lower byte) and mem_ub_n to the inverse of req_be[1] (upper byte), and loads mem_addr and mem_dout from the request.
- R3: The strobes stay low for exactly PULSE_CYC clock cycles (3 at defaults, 60 ns against a 45 ns minimum) and all rise on the same edge.
- R4: mem_dq_oe is 1 and mem_dout is unchanged for the whole time the strobes are low, and mem_dq_oe returns to 0 on the edge where the strobes rise.
- R5: mem_addr changes only on an edge that starts a new write; it holds its value through recovery and the idle time that follows.
- R6: Between the rise of mem_ce_n and its next fall there are at least RECOV_CYC + CEH_CYC + 1 cycles (3 at defaults).
- R7: req_ready is 0 for exactly PULSE_CYC + RECOV_CYC + CEH_CYC cycles (5 at defaults) after an accepted write with a nonzero byte enable, and is 0 only while a write is in progress.
- R8: mem_oe_n is 1 in every cycle that mem_ce_n is 0; with IDLE_OE_EN = 0 (default) it is 1 at all times.
- R9: A request with req_be = 00 is accepted while req_ready stays 1, and no strobe goes low.
- R10: Chip enable is never held low longer than CE_CEIL_NS (1000 ns); parameter sets that would allow it fail elaboration.
- R11: The lane strobes are low only while mem_ce_n is 0, and mem_we_n equals mem_ce_n in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_addr | input | 21 | Word address of the write |
| req_data | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 lower byte, bit 1 upper byte |
| mem_addr | output | 21 | Address to the memory |
| mem_dout | output | 16 | Data driven onto the memory bus |
| mem_dq_oe | output | 1 | Enable of the data bus driver |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |

## Verification
The bound checker watches on every cycle that output enable stays high during selection, that the pulse reaches its minimum and the high gap its minimum, that chip enable never outlives the ceiling, that data stays put during the pulse and that the address moves only at a write's start. Only the bench scenarios can show that the right address, data and lanes reach the pins for each request, that ready stays low for exactly the expected count, and that a request with no byte enabled passes without any strobe while back-to-back writes still respect the gap.

// File: rtl/psram_wr_pkg.sv
// Shared types and elaboration helpers for the PSRAM write sequencer.
// Assumes all timing values are positive integers in nanoseconds.
package psram_wr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_RECOV = 2'd2,
        ST_GAP   = 2'd3
    } wr_state_t;

    // Rounded-up division of a nanosecond minimum by the clock period.
    function automatic int ns_to_cyc(input int ns, input int period);
        return (ns + period - 1) / period;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_wr_timer.sv
// Down-counter that times one sequencer phase.
// Loaded with N >= 1, it reports the last of N cycles through last_cyc.
module psram_wr_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last_cyc
);

    logic [CNT_W-1:0] cnt;

    // Reload on a phase start, otherwise count down toward one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last_cyc = (cnt <= CNT_W'(1));

endmodule

// File: rtl/psram_wr_seq.sv
// Phase sequencer: idle, write pulse, address recovery, chip-enable gap.
// Assumes the timer reports the last cycle of each loaded phase.
module psram_wr_seq
    import psram_wr_pkg::*;
#(
    parameter int CNT_W     = 3,
    parameter int PULSE_CYC = 3,
    parameter int RECOV_CYC = 1,
    parameter int CEH_CYC   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_be,
    input  logic             last_cyc,
    output logic             ready,
    output logic             start_wr,
    output logic             end_pulse,
    output logic             load,
    output logic [CNT_W-1:0] load_val
);

    wr_state_t st, st_nxt;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // Next state and the phase-event strobes.
    always_comb begin
        st_nxt    = st;
        start_wr  = 1'b0;
        end_pulse = 1'b0;
        load      = 1'b0;
        load_val  = '0;
        unique case (st)
            ST_IDLE: begin
                if (req_valid && (req_be != 2'b00)) begin
                    st_nxt   = ST_PULSE;
                    start_wr = 1'b1;
                    load     = 1'b1;
                    load_val = CNT_W'(PULSE_CYC);
                end
            end
            ST_PULSE: begin
                if (last_cyc) begin
                    st_nxt    = ST_RECOV;
                    end_pulse = 1'b1;
                    load      = 1'b1;
                    load_val  = CNT_W'(RECOV_CYC);
                end
            end
            ST_RECOV: begin
                if (last_cyc) begin
                    st_nxt   = ST_GAP;
                    load     = 1'b1;
                    load_val = CNT_W'(CEH_CYC);
                end
            end
            ST_GAP: begin
                if (last_cyc) st_nxt = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    assign ready = (st == ST_IDLE);

endmodule

// File: rtl/psram_wr_pins.sv
// Registered memory-side pins; every output comes straight from a flop.
// Assumes start_wr and end_pulse never coincide.
module psram_wr_pins #(
    parameter int ADDR_W     = 21,
    parameter int DATA_W     = 16,
    parameter bit IDLE_OE_EN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              end_pulse,
    input  logic              ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [1:0]        req_be,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dq_oe,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n
);

    localparam logic OE_IDLE_N = ~IDLE_OE_EN;

    // Address and data load only when a write starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_dout <= '0;
        end else if (start_wr) begin
            mem_addr <= req_addr;
            mem_dout <= req_data;
        end
    end

    // Strobes fall together at start and rise together at pulse end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_lb_n  <= 1'b1;
            mem_ub_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else if (start_wr) begin
            mem_ce_n  <= 1'b0;
            mem_we_n  <= 1'b0;
            mem_lb_n  <= ~req_be[0];
            mem_ub_n  <= ~req_be[1];
            mem_dq_oe <= 1'b1;
        end else if (end_pulse) begin
            mem_ce_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_lb_n  <= 1'b1;
            mem_ub_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end
    end

    // Output enable: forced high from write start, idle value otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)        mem_oe_n <= 1'b1;
        else if (start_wr) mem_oe_n <= 1'b1;
        else if (ready)    mem_oe_n <= OE_IDLE_N;
        else               mem_oe_n <= 1'b1;
    end

endmodule

// File: rtl/psram_wr_ctrl.sv
// Top of the asynchronous PSRAM write sequencer.
// Converts nanosecond minimums into cycle counts, rejects settings that
// break the chip-enable ceiling, and wires sequencer, timer and pins.
// Assumes a free-running clk of period CLK_NS and a synchronous reset.
module psram_wr_ctrl
    import psram_wr_pkg::*;
#(
    parameter int ADDR_W       = 21,
    parameter int DATA_W       = 16,
    parameter int CLK_NS       = 20,
    parameter int PULSE_MIN_NS = 45,
    parameter int RECOV_MIN_NS = 15,
    parameter int CYCLE_MIN_NS = 80,
    parameter int SETUP_MIN_NS = 20,
    parameter int CEH_MIN_NS   = 15,
    parameter int CE_CEIL_NS   = 1000,
    parameter bit IDLE_OE_EN   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [1:0]        req_be,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dq_oe,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n
);

    localparam int RECOV_CYC = imax(1, ns_to_cyc(RECOV_MIN_NS, CLK_NS));
    localparam int CEH_CYC   = imax(1, ns_to_cyc(CEH_MIN_NS, CLK_NS));
    localparam int PULSE_CYC = imax(imax(1, ns_to_cyc(PULSE_MIN_NS, CLK_NS)),
                                    imax(ns_to_cyc(SETUP_MIN_NS, CLK_NS),
                                         ns_to_cyc(CYCLE_MIN_NS, CLK_NS) - RECOV_CYC));
    localparam int MAX_CYC   = imax(PULSE_CYC, imax(RECOV_CYC, CEH_CYC));
    localparam int CNT_W     = $clog2(MAX_CYC + 1);
    localparam int GAP_MIN   = RECOV_CYC + CEH_CYC + 1;

    // R10: refuse settings whose pulse or cycle passes the ceiling.
    generate
        if ((PULSE_CYC + RECOV_CYC) * CLK_NS > CE_CEIL_NS) begin : g_bad_timing
            $error("psram_wr_ctrl: write cycle exceeds chip-enable ceiling");
        end
    endgenerate

    logic             start_wr;
    logic             end_pulse;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             last_cyc;

    psram_wr_seq #(
        .CNT_W     (CNT_W),
        .PULSE_CYC (PULSE_CYC),
        .RECOV_CYC (RECOV_CYC),
        .CEH_CYC   (CEH_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_be    (req_be),
        .last_cyc  (last_cyc),
        .ready     (req_ready),
        .start_wr  (start_wr),
        .end_pulse (end_pulse),
        .load      (load),
        .load_val  (load_val)
    );

    psram_wr_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .last_cyc (last_cyc)
    );

    psram_wr_pins #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .IDLE_OE_EN (IDLE_OE_EN)
    ) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_wr  (start_wr),
        .end_pulse (end_pulse),
        .ready     (req_ready),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .req_be    (req_be),
        .mem_addr  (mem_addr),
        .mem_dout  (mem_dout),
        .mem_dq_oe (mem_dq_oe),
        .mem_ce_n  (mem_ce_n),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .mem_lb_n  (mem_lb_n),
        .mem_ub_n  (mem_ub_n)
    );

endmodule

// File: rtl/psram_wr_ctrl_chk.sv
// Timing checker bound to psram_wr_ctrl; measures strobe intervals
// with saturating run counters rather than long $past windows.
module psram_wr_ctrl_chk #(
    parameter int ADDR_W     = 21,
    parameter int DATA_W     = 16,
    parameter int PULSE_CYC  = 3,
    parameter int GAP_MIN    = 3,
    parameter int CLK_NS     = 20,
    parameter int CE_CEIL_NS = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dout,
    input logic              mem_dq_oe,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_lb_n,
    input logic              mem_ub_n
);

    logic [7:0] low_run;
    logic [7:0] high_run;

    // Count consecutive cycles with chip enable low and high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run  <= 8'd0;
            high_run <= 8'hFF;
        end else if (mem_ce_n) begin
            low_run  <= 8'd0;
            high_run <= (high_run == 8'hFF) ? high_run : high_run + 8'd1;
        end else begin
            high_run <= 8'd0;
            low_run  <= (low_run == 8'hFF) ? low_run : low_run + 8'd1;
        end
    end

    a_r3_pulse_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n) |-> (int'(low_run) >= PULSE_CYC));

    a_r4_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_dout) && mem_dq_oe));

    a_r5_addr_moves_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_addr) |-> ($past(mem_ce_n) && !mem_ce_n));

    a_r6_ce_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> (int'(high_run) >= GAP_MIN));

    a_r7_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_ce_n);

    a_r8_oe_high_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> mem_oe_n);

    a_r10_ce_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> (int'(low_run) * CLK_NS < CE_CEIL_NS));

    a_r11_lanes_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_lb_n || !mem_ub_n) |-> (!mem_ce_n && !mem_we_n));

endmodule

bind psram_wr_ctrl psram_wr_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PULSE_CYC  (PULSE_CYC),
    .GAP_MIN    (GAP_MIN),
    .CLK_NS     (CLK_NS),
    .CE_CEIL_NS (CE_CEIL_NS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .mem_addr  (mem_addr),
    .mem_dout  (mem_dout),
    .mem_dq_oe (mem_dq_oe),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_lb_n  (mem_lb_n),
    .mem_ub_n  (mem_ub_n)
);

// File: tb/psram_wr_ctrl_test.sv
// Scoreboard bench: the driver queues expected writes, a forked monitor
// pops them at each chip-enable fall and measures every strobe interval.
module psram_wr_ctrl_test;

    localparam int EXP_PULSE = 3;   // cycles, 20 ns clock
    localparam int EXP_BUSY  = 5;   // ready-low cycles per write
    localparam int EXP_GAP   = 3;   // minimum chip-enable high cycles

    typedef struct packed {
        logic [20:0] addr;
        logic [15:0] data;
        logic [1:0]  be;
    } wr_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [20:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic [1:0]  req_be = '0;
    logic [20:0] mem_addr;
    logic [15:0] mem_dout;
    logic        mem_dq_oe;
    logic        mem_ce_n;
    logic        mem_we_n;
    logic        mem_oe_n;
    logic        mem_lb_n;
    logic        mem_ub_n;

    int n_checks = 0;
    int n_errors = 0;
    wr_item_t exp_q[$];

    always #10 clk = ~clk;

    psram_wr_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .req_be    (req_be),
        .mem_addr  (mem_addr),
        .mem_dout  (mem_dout),
        .mem_dq_oe (mem_dq_oe),
        .mem_ce_n  (mem_ce_n),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .mem_lb_n  (mem_lb_n),
        .mem_ub_n  (mem_ub_n)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: waits for ready, presents one request, measures busy time.
    task automatic send(input logic [20:0] a, input logic [15:0] d, input logic [1:0] be);
        int busy;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_data  = d;
        req_be    = be;
        if (be != 2'b00) exp_q.push_back('{addr: a, data: d, be: be});
        @(negedge clk);
        req_valid = 1'b0;
        if (be == 2'b00) begin
            chk(req_ready == 1'b1, "R9 ready after null request", req_ready, 1);
            for (int k = 0; k < 4; k++) begin
                chk(mem_ce_n && mem_lb_n && mem_ub_n, "R9 no strobe on null request",
                    {mem_ce_n, mem_lb_n, mem_ub_n}, 3'b111);
                @(negedge clk);
            end
        end else begin
            busy = 0;
            while (!req_ready && busy < 50) begin
                busy++;
                @(negedge clk);
            end
            chk(busy == EXP_BUSY, "R7 ready-low cycles", busy, EXP_BUSY);
        end
    endtask

    // Monitor: pops expected writes at chip-enable fall, times intervals.
    task automatic monitor();
        logic        prev_ce = 1'b1;
        int          low_cnt = 0;
        int          high_cnt = 0;
        bit          seen = 1'b0;
        wr_item_t    cur = '0;
        forever begin
            @(negedge clk);
            if (!mem_ce_n && prev_ce) begin
                if (seen) chk(high_cnt >= EXP_GAP, "R6 chip-enable high gap", high_cnt, EXP_GAP);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 strobe without a write", 0, 1);
                end else begin
                    cur = exp_q.pop_front();
                    chk(mem_addr == cur.addr, "R2 address", mem_addr, cur.addr);
                    chk(mem_dout == cur.data, "R2 data", mem_dout, cur.data);
                    chk(mem_lb_n == ~cur.be[0], "R2 lower lane", mem_lb_n, ~cur.be[0]);
                    chk(mem_ub_n == ~cur.be[1], "R2 upper lane", mem_ub_n, ~cur.be[1]);
                    chk(mem_we_n == 1'b0, "R11 write enable with chip enable", mem_we_n, 0);
                    chk(mem_dq_oe == 1'b1, "R4 driver on at start", mem_dq_oe, 1);
                end
                seen = 1'b1;
                low_cnt = 1;
            end else if (!mem_ce_n) begin
                low_cnt++;
                chk(mem_dq_oe && mem_dout == cur.data, "R4 data held in pulse", mem_dout, cur.data);
                chk(mem_addr == cur.addr, "R5 address held in pulse", mem_addr, cur.addr);
            end else if (mem_ce_n && !prev_ce) begin
                chk(low_cnt == EXP_PULSE, "R3 pulse length", low_cnt, EXP_PULSE);
                chk(low_cnt * 20 < 1000, "R10 chip-enable ceiling", low_cnt * 20, 1000);
                chk(mem_we_n && mem_lb_n && mem_ub_n, "R11 strobes rise together",
                    {mem_we_n, mem_lb_n, mem_ub_n}, 3'b111);
                chk(mem_dq_oe == 1'b0, "R4 driver off at pulse end", mem_dq_oe, 0);
                chk(mem_addr == cur.addr, "R5 address in recovery", mem_addr, cur.addr);
                high_cnt = 1;
            end else begin
                high_cnt++;
                if (seen) chk(mem_addr == cur.addr, "R5 address idle hold", mem_addr, cur.addr);
            end
            if (!mem_ce_n) chk(mem_oe_n == 1'b1, "R8 output enable high", mem_oe_n, 1);
            prev_ce = mem_ce_n;
        end
    endtask

    initial begin
        fork
            begin : watchdog
                repeat (20000) @(posedge clk);
                n_errors++;
                n_checks++;
                $display("FAIL watchdog expired at %0t", $time);
                $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_we_n && mem_lb_n && mem_ub_n && mem_oe_n,
            "R1 strobes high in reset", {mem_ce_n, mem_we_n, mem_lb_n, mem_ub_n, mem_oe_n}, 5'h1F);
        chk(mem_dq_oe == 1'b0, "R1 driver off in reset", mem_dq_oe, 0);
        chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        fork
            monitor();
        join_none

        send(21'h000000, 16'hA5A5, 2'b11);
        send(21'h1FFFFF, 16'h5A5A, 2'b01);
        send(21'h0ABCDE, 16'hFFFF, 2'b10);
        send(21'h012345, 16'h1234, 2'b00);
        send(21'h000001, 16'h0000, 2'b11);
        repeat (4) @(negedge clk);
        send(21'h155555, 16'hC3C3, 2'b10);
        send(21'h0AAAAA, 16'h3C3C, 2'b11);
        send(21'h100000, 16'h8001, 2'b01);
        repeat (6) @(negedge clk);

        chk(mem_oe_n == 1'b1, "R8 output enable high when idle", mem_oe_n, 1);
        chk(exp_q.size() == 0, "R2 every queued write reached the pins", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule